// File: doc/BRIEF.md
# PHY Power and Suspend Sequencer

This block walks a 32-bit PHY control word through the ordered, timed bit changes that a PHY needs at power-up, when it enters retention and when it leaves retention. It replaces a software routine that would otherwise write the word bit by bit and sleep between the writes. An init request runs the power-up order: reset pulse, pad reference clock selection and a clock-settle wait, then lane power and reference enable together, followed by a final settle wait. A suspend request shuts the reference clock off and enters retention. A resume request reverses that and, where needed, pulses reset.

Several users may share the PHY, so suspend and resume requests pass through a use counter. Only the suspend that releases the last user, and the resume that brings in the first user, move the word. All waits are counted in clock cycles. A cycles-per-microsecond parameter scales them. A mode input selects whether the reset pulse goes to a separate external reset line or to the reset bit of the word. A second input marks a secondary instance, which never drives reset on resume. Requests that arrive while a sequence runs are refused with a one-cycle pulse and have no effect.

Top module: `phy_pwr_seq`

## Requirements
- R1: While rst_n is low and on release, ctrl_word is 0 and ext_reset, busy, done, refused and underflow are all 0; the use count is 0 and the PHY counts as not suspended.
- R2: An accepted init with ext_reset_mode low, one cycle after acceptance, sets bit 7 for RST_US*CYC_PER_US cycles and then clears it. The next cycle it sets bit 28, waits PAD_US*CYC_PER_US cycles, then sets bits 24 and 8 in the same cycle and waits PWR_US*CYC_PER_US cycles before the sequence ends.
- R3: An init with ext_reset_mode high has the same timing as R2, but the reset pulse appears on ext_reset and bit 7 is not touched.
- R4: An acting suspend clears bit 8, then bit 28 on the next cycle, then sets bit 26 on the next. If ext_reset_mode was high and secondary low, it asserts ext_reset one cycle later and leaves it asserted.
- R5: An acting resume with both mode inputs low sets bit 7, then bit 28, then bit 8, then clears bit 26, each on its own cycle. It then waits RST_US*CYC_PER_US cycles and clears bit 7 on the next cycle.
- R6: An acting resume with ext_reset_mode high and secondary low first releases ext_reset and then follows the order of R5 with no reset wait. With secondary high, the reset step is skipped and the sequence starts at bit 28.
- R7: A suspend decrements the use count, which is never below 0. It starts a sequence only when the count before it is 0 or 1 and the PHY is not suspended.
- R8: A resume increments the use count, which saturates at its maximum. It starts a sequence only when the count before it is 0 and the PHY is suspended; otherwise busy stays 0 and ctrl_word is unchanged.
- R9: A suspend taken while the use count is 0 leaves the count at 0 and pulses underflow for one cycle. It still acts if the PHY is not suspended.
- R10: Any request that arrives while busy is high pulses refused one cycle later and changes neither ctrl_word, ext_reset nor the use count.
- R11: Requests that arrive together while idle are ranked init, then suspend, then resume. Only the winner is taken, and refused pulses for the others.
- R12: ext_reset_mode and secondary are sampled when a request is taken; changes during the sequence do not alter it.
- R13: busy is high from the cycle after acceptance until the sequence ends. done pulses for exactly one cycle as busy falls. A filtered request raises neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Start the power-up sequence |
| suspend_req | input | 1 | One user releases the PHY |
| resume_req | input | 1 | One user claims the PHY |
| ext_reset_mode | input | 1 | 1: reset pulses go to ext_reset; 0: to bit 7 of ctrl_word |
| secondary | input | 1 | 1: instance never drives reset on resume |
| ctrl_word | output | 32 | PHY control word (bits 7, 8, 24, 26, 28 used) |
| ext_reset | output | 1 | External PHY reset line |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| refused | output | 1 | One-cycle pulse for a request that was not taken |
| underflow | output | 1 | One-cycle pulse for a suspend at use count 0 |

## Verification
A wrong step state shows up on ctrl_word or ext_reset in the very next cycle, because every step writes exactly one change. A timer off by one moves the next bit change by a cycle. A drifting use count stays hidden until a later suspend or resume acts, or fails to act, where it should not. The bench therefore runs chains of suspend and resume requests, so that a count error shows within a few requests as a whole sequence that appears or goes missing. A latched-mode error shows as reset activity on the wrong line.

// File: rtl/phy_pwr_seq_pkg.sv
package phy_pwr_seq_pkg;
    localparam int WORD_W    = 32;
    localparam int B_RST     = 7;
    localparam int B_REFEN   = 8;
    localparam int B_LANEPWR = 24;
    localparam int B_RETAIN  = 26;
    localparam int B_PADCLK  = 28;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_I_RST_ON, ST_I_RST_WAIT, ST_I_RST_OFF,
        ST_I_PAD_ON, ST_I_PAD_WAIT,
        ST_I_PWR_ON, ST_I_PWR_WAIT,
        ST_S_REF_OFF, ST_S_PAD_OFF, ST_S_RET_ON, ST_S_XRST_ON,
        ST_R_RST, ST_R_PAD_ON, ST_R_REF_ON, ST_R_RET_OFF,
        ST_R_RST_WAIT, ST_R_RST_OFF
    } seq_state_e;

    typedef enum logic [1:0] {
        WT_RST,
        WT_PAD,
        WT_PWR
    } wait_sel_e;
endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer
    import phy_pwr_seq_pkg::*;
#(
    parameter int CYC_PER_US = 50,
    parameter int RST_US     = 10,
    parameter int PAD_US     = 30000,
    parameter int PWR_US     = 2000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  wait_sel_e sel,
    output logic      expired
);
    localparam int RST_CYC = RST_US * CYC_PER_US;
    localparam int PAD_CYC = PAD_US * CYC_PER_US;
    localparam int PWR_CYC = PWR_US * CYC_PER_US;
    localparam int MAX_A   = (RST_CYC > PAD_CYC) ? RST_CYC : PAD_CYC;
    localparam int MAX_CYC = (MAX_A > PWR_CYC) ? MAX_A : PWR_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            case (sel)
                WT_PAD:  tmr_d.cnt = CNT_W'(PAD_CYC - 1);
                WT_PWR:  tmr_d.cnt = CNT_W'(PWR_CYC - 1);
                default: tmr_d.cnt = CNT_W'(RST_CYC - 1);
            endcase
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = (tmr_q.cnt == '0);

    // R2: a running wait loses exactly one count per cycle
    a_r2_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && tmr_q.cnt != '0) |=> (tmr_q.cnt == $past(tmr_q.cnt) - CNT_W'(1)));
endmodule

// File: rtl/phy_seq_usecount.sv
module phy_seq_usecount #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dec,
    input  logic inc,
    output logic sus_go,
    output logic res_go,
    output logic underflow
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             susp;
        logic             uf;
    } use_t;

    use_t use_d, use_q;

    assign sus_go    = (use_q.cnt <= CNT_W'(1)) && !use_q.susp;
    assign res_go    = (use_q.cnt == '0) && use_q.susp;
    assign underflow = use_q.uf;

    always_comb begin
        use_d    = use_q;
        use_d.uf = 1'b0;
        if (dec) begin
            use_d.uf = (use_q.cnt == '0);
            if (use_q.cnt != '0) use_d.cnt = use_q.cnt - CNT_W'(1);
            if (sus_go) use_d.susp = 1'b1;
        end else if (inc) begin
            if (use_q.cnt != CNT_MAX) use_d.cnt = use_q.cnt + CNT_W'(1);
            if (res_go) use_d.susp = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) use_q <= '0;
        else        use_q <= use_d;
    end

    // R9: the underflow pulse only ever comes with the floor value
    a_r9_floor_held: assert property (@(posedge clk) disable iff (!rst_n)
        use_q.uf |-> (use_q.cnt == '0));
    // R8: an unsaturated resume adds exactly one
    a_r8_inc_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && use_q.cnt != CNT_MAX) |=> (use_q.cnt == $past(use_q.cnt) + CNT_W'(1)));
    // R7: entering suspended state needs a count of at most one before
    a_r7_last_user: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(use_q.susp) |-> ($past(use_q.cnt) <= CNT_W'(1)));
endmodule

// File: rtl/phy_seq_engine.sv
module phy_seq_engine
    import phy_pwr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic              ext_reset_mode,
    input  logic              secondary,
    input  logic              sus_go,
    input  logic              res_go,
    input  logic              tmr_exp,
    output logic              cnt_dec,
    output logic              cnt_inc,
    output logic              tmr_start,
    output wait_sel_e         tmr_sel,
    output logic [WORD_W-1:0] ctrl_word,
    output logic              ext_reset,
    output logic              busy,
    output logic              done,
    output logic              refused
);
    typedef struct packed {
        seq_state_e        st;
        logic [WORD_W-1:0] word;
        logic              xrst;
        logic              ext_m;
        logic              sec;
        logic              done;
        logic              refused;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d         = eng_q;
        eng_d.done    = 1'b0;
        eng_d.refused = 1'b0;
        cnt_dec       = 1'b0;
        cnt_inc       = 1'b0;
        tmr_start     = 1'b0;
        tmr_sel       = WT_RST;
        case (eng_q.st)
            ST_IDLE: begin
                if (init_req) begin
                    eng_d.st      = ST_I_RST_ON;
                    eng_d.ext_m   = ext_reset_mode;
                    eng_d.sec     = secondary;
                    eng_d.refused = suspend_req | resume_req;
                end else if (suspend_req) begin
                    cnt_dec       = 1'b1;
                    eng_d.refused = resume_req;
                    if (sus_go) begin
                        eng_d.st    = ST_S_REF_OFF;
                        eng_d.ext_m = ext_reset_mode;
                        eng_d.sec   = secondary;
                    end
                end else if (resume_req) begin
                    cnt_inc = 1'b1;
                    if (res_go) begin
                        eng_d.st    = secondary ? ST_R_PAD_ON : ST_R_RST;
                        eng_d.ext_m = ext_reset_mode;
                        eng_d.sec   = secondary;
                    end
                end
            end
            ST_I_RST_ON: begin
                if (eng_q.ext_m) eng_d.xrst = 1'b1;
                else             eng_d.word[B_RST] = 1'b1;
                tmr_start = 1'b1;
                tmr_sel   = WT_RST;
                eng_d.st  = ST_I_RST_WAIT;
            end
            ST_I_RST_WAIT: if (tmr_exp) eng_d.st = ST_I_RST_OFF;
            ST_I_RST_OFF: begin
                if (eng_q.ext_m) eng_d.xrst = 1'b0;
                else             eng_d.word[B_RST] = 1'b0;
                eng_d.st = ST_I_PAD_ON;
            end
            ST_I_PAD_ON: begin
                eng_d.word[B_PADCLK] = 1'b1;
                tmr_start = 1'b1;
                tmr_sel   = WT_PAD;
                eng_d.st  = ST_I_PAD_WAIT;
            end
            ST_I_PAD_WAIT: if (tmr_exp) eng_d.st = ST_I_PWR_ON;
            ST_I_PWR_ON: begin
                eng_d.word[B_LANEPWR] = 1'b1;
                eng_d.word[B_REFEN]   = 1'b1;
                tmr_start = 1'b1;
                tmr_sel   = WT_PWR;
                eng_d.st  = ST_I_PWR_WAIT;
            end
            ST_I_PWR_WAIT: begin
                if (tmr_exp) begin
                    eng_d.st   = ST_IDLE;
                    eng_d.done = 1'b1;
                end
            end
            ST_S_REF_OFF: begin
                eng_d.word[B_REFEN] = 1'b0;
                eng_d.st = ST_S_PAD_OFF;
            end
            ST_S_PAD_OFF: begin
                eng_d.word[B_PADCLK] = 1'b0;
                eng_d.st = ST_S_RET_ON;
            end
            ST_S_RET_ON: begin
                eng_d.word[B_RETAIN] = 1'b1;
                if (eng_q.ext_m && !eng_q.sec) begin
                    eng_d.st = ST_S_XRST_ON;
                end else begin
                    eng_d.st   = ST_IDLE;
                    eng_d.done = 1'b1;
                end
            end
            ST_S_XRST_ON: begin
                eng_d.xrst = 1'b1;
                eng_d.st   = ST_IDLE;
                eng_d.done = 1'b1;
            end
            ST_R_RST: begin
                if (eng_q.ext_m) eng_d.xrst = 1'b0;
                else             eng_d.word[B_RST] = 1'b1;
                eng_d.st = ST_R_PAD_ON;
            end
            ST_R_PAD_ON: begin
                eng_d.word[B_PADCLK] = 1'b1;
                eng_d.st = ST_R_REF_ON;
            end
            ST_R_REF_ON: begin
                eng_d.word[B_REFEN] = 1'b1;
                eng_d.st = ST_R_RET_OFF;
            end
            ST_R_RET_OFF: begin
                eng_d.word[B_RETAIN] = 1'b0;
                if (eng_q.ext_m || eng_q.sec) begin
                    eng_d.st   = ST_IDLE;
                    eng_d.done = 1'b1;
                end else begin
                    tmr_start = 1'b1;
                    tmr_sel   = WT_RST;
                    eng_d.st  = ST_R_RST_WAIT;
                end
            end
            ST_R_RST_WAIT: if (tmr_exp) eng_d.st = ST_R_RST_OFF;
            ST_R_RST_OFF: begin
                eng_d.word[B_RST] = 1'b0;
                eng_d.st   = ST_IDLE;
                eng_d.done = 1'b1;
            end
            default: eng_d.st = ST_IDLE;
        endcase
        if (eng_q.st != ST_IDLE)
            eng_d.refused = init_req | suspend_req | resume_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign ctrl_word = eng_q.word;
    assign ext_reset = eng_q.xrst;
    assign busy      = (eng_q.st != ST_IDLE);
    assign done      = eng_q.done;
    assign refused   = eng_q.refused;

    // R4: retention only goes on after reference clock and its enable are off
    a_r4_retain_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_q.word[B_RETAIN]) |-> (!eng_q.word[B_REFEN] && !eng_q.word[B_PADCLK]));
    // R5: retention is released only with clock source and enable back on
    a_r5_release_after_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_q.word[B_RETAIN]) |-> (eng_q.word[B_REFEN] && eng_q.word[B_PADCLK]));
    // R2: lane power comes up with clock running and reset released
    a_r2_power_after_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_q.word[B_LANEPWR]) |-> (eng_q.word[B_REFEN] && eng_q.word[B_PADCLK] && !eng_q.word[B_RST]));
    // R10: outputs move only while a sequence was running
    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(eng_q.word) && $stable(eng_q.xrst)) |-> $past(eng_q.st != ST_IDLE));
    // R13: done is a single-cycle pulse seen with busy low
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.done |=> !eng_q.done);
    a_r13_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.done |-> (eng_q.st == ST_IDLE));
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
    import phy_pwr_seq_pkg::*;
#(
    parameter int CYC_PER_US = 50,
    parameter int RST_US     = 10,
    parameter int PAD_US     = 30000,
    parameter int PWR_US     = 2000,
    parameter int USE_CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic              ext_reset_mode,
    input  logic              secondary,
    output logic [WORD_W-1:0] ctrl_word,
    output logic              ext_reset,
    output logic              busy,
    output logic              done,
    output logic              refused,
    output logic              underflow
);
    logic      sus_go, res_go, cnt_dec, cnt_inc, tmr_start, tmr_exp;
    wait_sel_e tmr_sel;

    phy_seq_engine u_engine (
        .clk            (clk),
        .rst_n          (rst_n),
        .init_req       (init_req),
        .suspend_req    (suspend_req),
        .resume_req     (resume_req),
        .ext_reset_mode (ext_reset_mode),
        .secondary      (secondary),
        .sus_go         (sus_go),
        .res_go         (res_go),
        .tmr_exp        (tmr_exp),
        .cnt_dec        (cnt_dec),
        .cnt_inc        (cnt_inc),
        .tmr_start      (tmr_start),
        .tmr_sel        (tmr_sel),
        .ctrl_word      (ctrl_word),
        .ext_reset      (ext_reset),
        .busy           (busy),
        .done           (done),
        .refused        (refused)
    );

    phy_seq_usecount #(.CNT_W(USE_CNT_W)) u_usecount (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec       (cnt_dec),
        .inc       (cnt_inc),
        .sus_go    (sus_go),
        .res_go    (res_go),
        .underflow (underflow)
    );

    phy_seq_timer #(
        .CYC_PER_US (CYC_PER_US),
        .RST_US     (RST_US),
        .PAD_US     (PAD_US),
        .PWR_US     (PWR_US)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .sel     (tmr_sel),
        .expired (tmr_exp)
    );
endmodule

// File: tb/sim_phy_pwr_seq.sv
module sim_phy_pwr_seq;
    localparam int CPU  = 2;
    localparam int RSTU = 3;
    localparam int PADU = 10;
    localparam int PWRU = 5;
    localparam int NRST = RSTU * CPU;
    localparam int NPAD = PADU * CPU;
    localparam int NPWR = PWRU * CPU;
    localparam int CMAX = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_req = 1'b0, suspend_req = 1'b0, resume_req = 1'b0;
    logic        ext_reset_mode = 1'b0, secondary = 1'b0;
    logic [31:0] ctrl_word;
    logic        ext_reset, busy, done, refused, underflow;

    always #10 clk = ~clk;

    phy_pwr_seq #(.CYC_PER_US(CPU), .RST_US(RSTU), .PAD_US(PADU), .PWR_US(PWRU), .USE_CNT_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .suspend_req(suspend_req),
        .resume_req(resume_req), .ext_reset_mode(ext_reset_mode), .secondary(secondary),
        .ctrl_word(ctrl_word), .ext_reset(ext_reset), .busy(busy), .done(done),
        .refused(refused), .underflow(underflow)
    );

    typedef struct {
        logic [31:0] setm;
        logic [31:0] clrm;
        int          ext;
    } step_t;

    step_t       q[$];
    logic [31:0] m_word;
    logic        m_ext, m_busy, m_done, m_ref, m_uf, m_susp;
    int          m_cnt;
    int          total = 0, bad = 0, cyc = 0;
    string       cur_req = "R1";

    function automatic void add(logic [31:0] s, logic [31:0] c, int e);
        step_t t;
        t.setm = s; t.clrm = c; t.ext = e;
        q.push_back(t);
    endfunction

    function automatic void add_wait(int n);
        for (int i = 0; i < n; i++) add(32'h0, 32'h0, -1);
    endfunction

    function automatic void build_init(logic xm);
        if (xm) add(32'h0, 32'h0, 1); else add(32'h80, 32'h0, -1);
        add_wait(NRST);
        if (xm) add(32'h0, 32'h0, 0); else add(32'h0, 32'h80, -1);
        add(32'h1000_0000, 32'h0, -1);
        add_wait(NPAD);
        add(32'h0100_0100, 32'h0, -1);
        add_wait(NPWR);
    endfunction

    function automatic void build_susp(logic xm, logic sc);
        add(32'h0, 32'h100, -1);
        add(32'h0, 32'h1000_0000, -1);
        add(32'h0400_0000, 32'h0, -1);
        if (xm && !sc) add(32'h0, 32'h0, 1);
    endfunction

    function automatic void build_res(logic xm, logic sc);
        if (!sc) begin
            if (xm) add(32'h0, 32'h0, 0); else add(32'h80, 32'h0, -1);
        end
        add(32'h1000_0000, 32'h0, -1);
        add(32'h100, 32'h0, -1);
        add(32'h0, 32'h0400_0000, -1);
        if (!xm && !sc) begin
            add_wait(NRST);
            add(32'h0, 32'h80, -1);
        end
    endfunction

    // behavioural reference model, one step per clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            m_word = '0; m_ext = 0; m_busy = 0; m_done = 0; m_ref = 0; m_uf = 0;
            m_susp = 0; m_cnt = 0;
        end else begin
            m_done = 0; m_ref = 0; m_uf = 0;
            if (q.size() > 0) begin
                step_t t;
                if (init_req || suspend_req || resume_req) m_ref = 1;
                t = q.pop_front();
                m_word = (m_word & ~t.clrm) | t.setm;
                if (t.ext >= 0) m_ext = t.ext[0];
                if (q.size() == 0) begin m_busy = 0; m_done = 1; end
            end else begin
                if (init_req) begin
                    if (suspend_req || resume_req) m_ref = 1;
                    build_init(ext_reset_mode);
                end else if (suspend_req) begin
                    bit go;
                    if (resume_req) m_ref = 1;
                    go = (m_cnt <= 1) && !m_susp;
                    if (m_cnt == 0) m_uf = 1; else m_cnt--;
                    if (go) begin m_susp = 1; build_susp(ext_reset_mode, secondary); end
                end else if (resume_req) begin
                    bit go;
                    go = (m_cnt == 0) && m_susp;
                    if (m_cnt < CMAX) m_cnt++;
                    if (go) begin m_susp = 0; build_res(ext_reset_mode, secondary); end
                end
                m_busy = (q.size() > 0);
            end
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        total++;
        if (ctrl_word !== m_word || ext_reset !== m_ext || busy !== m_busy ||
            done !== m_done || refused !== m_ref || underflow !== m_uf) begin
            bad++;
            $display("FAIL %s cyc=%0d word act=%h exp=%h ext act=%b exp=%b busy act=%b exp=%b done act=%b exp=%b refused act=%b exp=%b underflow act=%b exp=%b",
                     cur_req, cyc, ctrl_word, m_word, ext_reset, m_ext, busy, m_busy,
                     done, m_done, refused, m_ref, underflow, m_uf);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic pulse(input logic i, input logic s, input logic r);
        @(negedge clk);
        init_req = i; suspend_req = s; resume_req = r;
        @(negedge clk);
        init_req = 0; suspend_req = 0; resume_req = 0;
    endtask

    task automatic settle();
        do @(negedge clk); while (m_busy);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        cur_req = "R1";                         // R1 reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R2";  pulse(1, 0, 0); settle();   // R2 init, internal reset
        cur_req = "R8";  pulse(0, 0, 1); settle();   // R8 resume filtered, count 1
        cur_req = "R4";  pulse(0, 1, 0); settle();   // R4 suspend acts
        cur_req = "R9";  pulse(0, 1, 0); settle();   // R9 underflow, already suspended
        cur_req = "R5";  pulse(0, 0, 1); settle();   // R5 resume internal
        cur_req = "R7";  pulse(0, 0, 1); settle();   // R7 count 2
        pulse(0, 1, 0); settle();                    // R7 count 2 -> 1, no action
        pulse(0, 1, 0); settle();                    // R7 last user, acts

        cur_req = "R3";  ext_reset_mode = 1'b1;      // R3 init external reset
        pulse(1, 0, 0);
        repeat (3) @(negedge clk);
        cur_req = "R12"; ext_reset_mode = 1'b0;      // R12 mode change mid-run
        cur_req = "R10"; pulse(0, 1, 0);             // R10 refused while busy
        pulse(0, 0, 1);
        settle();
        ext_reset_mode = 1'b1;
        cur_req = "R6";  pulse(0, 0, 1); settle();   // R6 resume external
        cur_req = "R4";  pulse(0, 1, 0); settle();   // R4 suspend holds ext reset
        cur_req = "R6";  secondary = 1'b1;           // R6 secondary skips reset
        pulse(0, 0, 1); settle();
        cur_req = "R4";  pulse(0, 1, 0); settle();
        cur_req = "R6";  ext_reset_mode = 1'b0;
        pulse(0, 0, 1); settle();
        secondary = 1'b0;
        cur_req = "R11"; pulse(1, 1, 0); settle();   // R11 init beats suspend
        pulse(0, 1, 1); settle();                    // R11 suspend beats resume
        cur_req = "R13"; pulse(0, 1, 0); settle();   // R13 filtered: no busy, no done
        pulse(0, 0, 1); settle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule